// File: doc/BRIEF.md
# Six-Pin GPIO Controller with Level Interrupt

This block drives and samples six general-purpose pins through a small register file. Writes happen on a clock edge and reads return data in the same cycle. A configuration register gives every pin a 2-bit direction code. The same register selects one pin as the source of a level-sensitive interrupt, enables that interrupt and chooses its polarity. A separate output register holds the value that each output pin drives. An input register returns the synchronized pad levels through a fixed read mask.

Each pad input passes through a two-flop synchronizer. The synchronized value feeds both the input readback and the interrupt compare. The interrupt is registered and stays high for as long as the selected pin holds the chosen level. A mask register gates the interrupt before it leaves on the host-side line.

Register addresses: 0 is configuration, 1 is output data, 2 is input data (read-only), and 3 is the host interrupt mask (bit 0).

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` is zero, and `gpio_irq` and `host_irq` are low.
- R2: Configuration bits [2n+1:2n] are the direction code of pin n. Code 2'b11 sets `pad_oe[n]`. Codes 2'b00, 2'b01 and 2'b10 leave the pin as an input.
- R3: A write to address 1 stores bits [5:0]. Bit n drives `pad_out[n]` from the next cycle. Readback returns those bits with zeros above them, so a read-modify-write of one bit leaves the other bits unchanged.
- R4: A read of address 2 returns the pad inputs ANDed with 0x2F, as seen two clock edges after they change. Bit 4 and bits 31:6 always read zero.
- R5: When the interrupt enable (config bit 15) is set and the pin select (bits [14:12]) names pin n < 6, `pad_oe[n]` is low whatever its direction code.
- R6: With polarity bits [17:16] = 2'b11, `gpio_irq` rises on the third clock edge after the selected pad goes high. It stays high while the pad stays high.
- R7: With polarity 2'b01, `gpio_irq` asserts under the same timing while the selected pad is low.
- R8: `gpio_irq` stays low when the enable is clear, when the pin select is 6 or 7, or when the polarity is 2'b00 or 2'b10.
- R9: `host_irq` equals `gpio_irq` while mask bit 0 at address 3 is set, and is low while that bit is clear.
- R10: Configuration readback returns bits [17:0] as written, with bits 31:18 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| pad_in | input | 6 | Pad input levels, asynchronous |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |
| gpio_irq | output | 1 | Registered level interrupt |
| host_irq | output | 1 | Interrupt gated by the mask bit |

## Verification
The assertions assume that `reg_addr` and `reg_wr` are stable and known at every clock edge. They also assume that the pad inputs change only between edges, so the synchronizer latency is an exact number of cycles. The bench drives all inputs on the falling edge and changes one configuration or pad pattern at a time. It then waits the three edges an interrupt needs before it samples.

// File: rtl/gpio_pkg.sv
// Package: shared addresses, field positions and codes for the GPIO block.
// Assumes a 32-bit register port and the field layout fixed in BRIEF.md.
package gpio_pkg;
    localparam int NUM_PINS  = 6;
    localparam int DIR_W     = 2;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int SEL_W     = 3;

    localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DOUT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIN  = 2'd2;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd3;

    localparam int SEL_LSB  = NUM_PINS*DIR_W;    // 12
    localparam int EN_BIT   = SEL_LSB + SEL_W;   // 15
    localparam int POL_LSB  = EN_BIT + 1;        // 16
    localparam int CFG_W    = POL_LSB + 2;       // 18

    localparam logic [DIR_W-1:0] DIR_OUT  = 2'b11;
    localparam logic [1:0]       POL_LOW  = 2'b01;
    localparam logic [1:0]       POL_HIGH = 2'b11;

    localparam logic [NUM_PINS-1:0] IN_MASK = 6'b101111;

    typedef struct packed {
        logic [1:0]                polarity;
        logic                      irq_en;
        logic [SEL_W-1:0]          irq_sel;
        logic [NUM_PINS*DIR_W-1:0] dir;
    } cfg_t;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for a bus of asynchronous pad inputs.
// Assumes every bit is independent; no bus coherency is provided.
module gpio_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
// Module: register file with configuration, output data, input readback and
// interrupt mask. Writes on the clock edge, reads are combinational.
// Assumes addresses are decoded with gpio_pkg constants.
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] in_sync,
    output logic [DATA_W-1:0]   rdata,
    output cfg_t                cfg_q,
    output logic [NUM_PINS-1:0] dout_q,
    output logic                mask_q
);
    // Update the addressed writable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            dout_q <= '0;
            mask_q <= 1'b0;
        end else if (wr) begin
            case (addr)
                A_CFG:   cfg_q  <= cfg_t'(wdata[CFG_W-1:0]);
                A_DOUT:  dout_q <= wdata[NUM_PINS-1:0];
                A_MASK:  mask_q <= wdata[0];
                default: ;
            endcase
        end
    end

    // Select read data, zero-extending each register.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:   rdata[CFG_W-1:0]    = cfg_q;
            A_DOUT:  rdata[NUM_PINS-1:0] = dout_q;
            A_DIN:   rdata[NUM_PINS-1:0] = in_sync & IN_MASK;
            default: rdata[0]            = mask_q;
        endcase
    end
endmodule

// File: rtl/gpio_irq_gen.sv
// Module: level interrupt from one selected synchronized pin.
// Assumes in_sync is already synchronous; the output is registered.
module gpio_irq_gen
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  cfg_t                cfg,
    input  logic [NUM_PINS-1:0] in_sync,
    output logic                irq
);
    logic pin_lvl;
    logic pin_valid;
    logic cond;

    // Pick the selected pin level; selects past the last pin are invalid.
    always_comb begin
        pin_lvl   = 1'b0;
        pin_valid = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (cfg.irq_sel == SEL_W'(i)) begin
                pin_lvl   = in_sync[i];
                pin_valid = 1'b1;
            end
        end
    end

    // Apply enable and polarity to the selected level.
    always_comb begin
        cond = 1'b0;
        if (cfg.irq_en && pin_valid) begin
            case (cfg.polarity)
                POL_HIGH: cond = pin_lvl;
                POL_LOW:  cond = !pin_lvl;
                default:  cond = 1'b0;
            endcase
        end
    end

    // Register the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= cond;
    end
endmodule

// File: rtl/gpio_lvl_ctrl.sv
// Module: six-pin GPIO controller top. It combines the synchronizer, the
// register file, the per-pin direction decode and the level interrupt.
// Assumes pad_in is asynchronous and the register port is synchronous to clk.
module gpio_lvl_ctrl
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                gpio_irq,
    output logic                host_irq
);
    logic [NUM_PINS-1:0] in_sync;
    cfg_t                cfg_q;
    logic [NUM_PINS-1:0] dout_q;
    logic                mask_q;

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(in_sync)
    );

    gpio_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
        .wdata(reg_wdata), .in_sync(in_sync), .rdata(reg_rdata),
        .cfg_q(cfg_q), .dout_q(dout_q), .mask_q(mask_q)
    );

    gpio_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .in_sync(in_sync), .irq(gpio_irq)
    );

    // Per-pin direction decode; the interrupt pin is forced to input.
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic forced_in;
        assign forced_in  = cfg_q.irq_en && (cfg_q.irq_sel == SEL_W'(n));
        assign pad_oe[n]  = (cfg_q.dir[DIR_W*n +: DIR_W] == DIR_OUT) && !forced_in;
        assign pad_out[n] = dout_q[n];
    end

    // Gate the interrupt with the host mask bit.
    assign host_irq = gpio_irq & mask_q;
endmodule

// File: rtl/gpio_lvl_ctrl_chk.sv
// Module: assertion checker bound to gpio_lvl_ctrl.
// Assumes inputs are stable at clock edges.
module gpio_lvl_ctrl_chk
    import gpio_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                gpio_irq,
    input logic                host_irq,
    input cfg_t                cfg_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && !gpio_irq && !host_irq));

    // R3
    dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DOUT) |=> pad_out == $past(reg_wdata[NUM_PINS-1:0]));

    // R4
    din_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_DIN) |-> (reg_rdata[4] == 1'b0 && reg_rdata[DATA_W-1:NUM_PINS] == '0));

    // R5
    irq_pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.irq_en && cfg_q.irq_sel < SEL_W'(NUM_PINS)) |-> !pad_oe[cfg_q.irq_sel]);

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gpio_irq) |-> $past(cfg_q.irq_en));

    // R9
    host_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> gpio_irq);
endmodule

bind gpio_lvl_ctrl gpio_lvl_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .gpio_irq(gpio_irq), .host_irq(host_irq), .cfg_q(cfg_q)
);

// File: tb/gpio_lvl_ctrl_bench.sv
module gpio_lvl_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  pad_in = '0;
    logic [5:0]  pad_out, pad_oe;
    logic        gpio_irq, host_irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_lvl_ctrl u_gpio_lvl_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .gpio_irq(gpio_irq), .host_irq(host_irq)
    );

    // Vector: en[12] pol[11:10] sel[9:7] pad[6:1] expected irq[0]
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 2'b11, 3'd0, 6'b000001, 1'b1},
        {1'b1, 2'b11, 3'd0, 6'b000000, 1'b0},
        {1'b1, 2'b01, 3'd2, 6'b111011, 1'b1},
        {1'b1, 2'b01, 3'd2, 6'b111111, 1'b0},
        {1'b1, 2'b11, 3'd6, 6'b111111, 1'b0},
        {1'b1, 2'b10, 3'd1, 6'b111111, 1'b0},
        {1'b0, 2'b11, 3'd1, 6'b111111, 1'b0},
        {1'b1, 2'b11, 3'd5, 6'b100000, 1'b1},
        {1'b1, 2'b01, 3'd7, 6'b000000, 1'b0}
    };

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        @(negedge clk);
        tick(2);
        rst_n = 1'b1;

        // R1: reset state
        rd_reg(2'd0, d); check("R1 cfg", d, 0);
        rd_reg(2'd1, d); check("R1 dout", d, 0);
        rd_reg(2'd3, d); check("R1 mask", d, 0);
        check("R1 oe", {26'd0, pad_oe}, 0);
        check("R1 irq", {30'd0, gpio_irq, host_irq}, 0);

        // R2: direction codes; pins 0 and 3 output, others 00/01/10
        wr_reg(2'd0, 32'b0000_10_01_11_00_10_11);
        check("R2 oe", {26'd0, pad_oe}, 32'h09);

        // R3: output data, upper bits dropped, RMW keeps others
        wr_reg(2'd1, 32'hFFFF_FFC5);
        rd_reg(2'd1, d); check("R3 readback", d, 32'h05);
        check("R3 pad_out", {26'd0, pad_out}, 32'h05);
        wr_reg(2'd1, d | 32'h2);
        rd_reg(2'd1, d); check("R3 rmw", d, 32'h07);

        // R4: input readback masked, two-edge latency
        pad_in = 6'h3F;
        tick();
        rd_reg(2'd2, d); check("R4 one edge", d, 0);
        tick();
        rd_reg(2'd2, d); check("R4 masked", d, 32'h2F);

        // R10: config readback width
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_reg(2'd0, d); check("R10 cfg", d, 32'h3FFFF);

        // R5: all outputs, interrupt on pin 3 forces input
        wr_reg(2'd0, 32'h0000_BFFF);
        check("R5 forced", {26'd0, pad_oe}, 32'h37);

        // R6/R7/R8/R9: vector table, mask set
        wr_reg(2'd3, 32'h1);
        for (int v = 0; v < NV; v++) begin
            wr_reg(2'd0, {14'd0, VEC[v][11:10], VEC[v][12], VEC[v][9:7], 12'd0});
            pad_in = VEC[v][6:1];
            tick(3);
            check($sformatf("R6/R7/R8 vec%0d irq", v), {31'd0, gpio_irq}, {31'd0, VEC[v][0]});
            check($sformatf("R9 vec%0d host", v), {31'd0, host_irq}, {31'd0, VEC[v][0]});
        end

        // R6: latency and hold on pin 1 active-high
        pad_in = 6'h00;
        wr_reg(2'd0, {14'd0, 2'b11, 1'b1, 3'd1, 12'd0});
        tick(3);
        check("R6 idle", {31'd0, gpio_irq}, 0);
        pad_in = 6'h02;
        tick(2);
        check("R6 two edges", {31'd0, gpio_irq}, 0);
        tick();
        check("R6 third edge", {31'd0, gpio_irq}, 1);
        tick(5);
        check("R6 held", {31'd0, gpio_irq}, 1);

        // R7: active-low on pin 1 drops while high
        wr_reg(2'd0, {14'd0, 2'b01, 1'b1, 3'd1, 12'd0});
        tick();
        check("R7 high pad", {31'd0, gpio_irq}, 0);

        // R9: mask clear hides interrupt
        wr_reg(2'd0, {14'd0, 2'b11, 1'b1, 3'd1, 12'd0});
        wr_reg(2'd3, 32'h0);
        tick();
        check("R9 masked gpio", {31'd0, gpio_irq}, 1);
        check("R9 masked host", {31'd0, host_irq}, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule